// File: doc/BRIEF.md
# Paged ROM Address Latch and Counter

This block is the address front end of a sequential, page-organised word ROM. The ROM has 4M words of 16 bits, arranged as 16K pages of 256 words. It shares one 16-bit bus for address input and data output. The address arrives in two halves. A high-half latch strobe and a low-half latch strobe each capture one word from the bus on their falling edge. Only some bits of each half are kept.

The low half seeds an 8-bit in-page counter. Each falling edge of the active-low read strobe advances that counter, and the page bits stay put. After the last word of a page the counter wraps to word 0 of the same page. The block reports its operating mode and forms the 22-bit word address. It drives the bus output enable while a read is in progress.

All strobes and the bus pass through a synchroniser clocked by the system clock. Edges are found by comparing the synchronised level with a registered copy. A small computed stand-in array provides the word data.

Top module: `prl_front`

## Requirements
- R1: After reset, `mode` is 0 (standby), `word_addr` is 0, and `ad_oe`, `ad_out` and `seq_err` are 0.
- R2: At a falling edge of `ale_hi`, bus bits 6..0 are stored as `word_addr[21:15]` and bus bits 15..7 are ignored. The mode then becomes 1 (address input) and stays there until a low-half capture.
- R3: At a falling edge of `ale_lo` that follows a high-half capture with no low-half capture in between, the following happens:
  - bus bits 15..9 become `word_addr[14:8]`;
  - bus bits 8..1 load the in-page counter `word_addr[7:0]`;
  - bus bit 0 is ignored;
  - the mode becomes 2 (active).
- R4: In active mode, each falling edge of `rd_n` adds one to `word_addr[7:0]` and leaves `word_addr[21:8]` unchanged.
- R5: An increment from in-page word 255 gives word 0 of the same page.
- R6: A falling edge of `rd_n` while the mode is not active leaves `word_addr` unchanged.
- R7: `ad_oe` is 1 only while the mode is active and the synchronised `rd_n` is low. While `ad_oe` is 0, `ad_out` is 0.
- R8: While `ad_oe` is 1, `ad_out` shows the stand-in word for the address that was current at the read-strobe fall. For address A that word is `A[15:0] XOR {A[21:16], 10'b0}`.
- R9: An `ale_lo` falling edge with no pending high-half capture is a sequencing error. This includes the case where it comes directly after reset. On such an edge:
  - `seq_err` pulses for exactly one clock;
  - `word_addr` is unchanged;
  - the mode becomes 0.
- R10: While either latch strobe is high (synchronised), the mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_hi | input | 1 | High-half address latch strobe, captured on falling edge |
| ale_lo | input | 1 | Low-half address latch strobe, captured on falling edge |
| rd_n | input | 1 | Active-low read strobe; a falling edge advances the in-page counter |
| ad_in | input | 16 | Bus value seen by the block (address words) |
| ad_out | output | 16 | Word data driven onto the bus during a read |
| ad_oe | output | 1 | Bus output enable |
| word_addr | output | 22 | Word address: page high bits, page low bits, in-page counter |
| mode | output | 2 | 0 standby, 1 address input, 2 active |
| seq_err | output | 1 | One-clock pulse on a low-half capture with no pending high half |

## Verification
The main function is tried with three kinds of address word.

- A bus word with all unused high bits set (0xFF85) shows that bits 15..7 of the high half are dropped.
- Low words with bit 0 set show that bit 0 is dropped.
- Counter seeds of 0x10, 0xFE and 0xFF separate a plain increment from a page wrap.

Read strobes are given in standby, in address-input mode and in active mode, which shows that only the active mode advances the counter. Low-half captures are tried right after reset, after a completed address and after a proper high half. This separates a valid load from the sequencing error.

// File: rtl/prl_pkg.sv
package prl_pkg;

    typedef enum logic [1:0] {
        PRL_STANDBY = 2'd0,
        PRL_ADDR_IN = 2'd1,
        PRL_ACTIVE  = 2'd2
    } prl_mode_e;

endpackage

// File: rtl/prl_sync_pipe.sv
module prl_sync_pipe #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= RST_VAL;
                    else        stg_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= RST_VAL;
                    else        stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/prl_edge.sv
module prl_edge #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic fall
);

    logic lvl_s;
    logic prev_q;

    prl_sync_pipe #(
        .W      (1),
        .STAGES (STAGES),
        .RST_VAL(IDLE)
    ) u_pipe (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (din),
        .q    (lvl_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= lvl_s;
    end

    assign lvl  = lvl_s;
    assign fall = prev_q & ~lvl_s;

endmodule

// File: rtl/prl_array_stub.sv
module prl_array_stub #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int UP_W  = ADDR_W - DATA_W;
    localparam int PAD_W = DATA_W - UP_W;

    logic [DATA_W-1:0] upper_shifted;

    assign upper_shifted = {addr[ADDR_W-1:DATA_W], {PAD_W{1'b0}}};
    assign data          = addr[DATA_W-1:0] ^ upper_shifted;

endmodule

// File: rtl/prl_front.sv
module prl_front #(
    parameter int AD_W        = 16,
    parameter int HI_BITS     = 7,
    parameter int LO_BITS     = 7,
    parameter int CNT_BITS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = HI_BITS + LO_BITS + CNT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_hi,
    input  logic              ale_lo,
    input  logic              rd_n,
    input  logic [AD_W-1:0]   ad_in,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-1:0] word_addr,
    output logic [1:0]        mode,
    output logic              seq_err
);

    import prl_pkg::*;

    localparam int CNT_LSB = 1;
    localparam int CNT_MSB = CNT_BITS;
    localparam int LO_LSB  = CNT_BITS + 1;
    localparam int LO_MSB  = CNT_BITS + LO_BITS;

    typedef struct packed {
        prl_mode_e           mode;
        logic [HI_BITS-1:0]  hi;
        logic [LO_BITS-1:0]  lo;
        logic [CNT_BITS-1:0] cnt;
        logic                armed;
        logic                err;
        logic                oe;
        logic [AD_W-1:0]     dout;
    } prl_state_t;

    prl_state_t st_d, st_q;

    logic            hi_lvl, hi_fall;
    logic            lo_lvl, lo_fall;
    logic            rd_lvl, rd_fall;
    logic [AD_W-1:0] ad_s;
    logic [AD_W-1:0] rom_word;
    logic            unused_ad_bit;

    // strobe synchronisers with edge detection
    prl_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_hi_edge (
        .clk(clk), .rst_n(rst_n), .din(ale_hi), .lvl(hi_lvl), .fall(hi_fall)
    );

    prl_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_lo_edge (
        .clk(clk), .rst_n(rst_n), .din(ale_lo), .lvl(lo_lvl), .fall(lo_fall)
    );

    prl_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rd_edge (
        .clk(clk), .rst_n(rst_n), .din(rd_n), .lvl(rd_lvl), .fall(rd_fall)
    );

    // bus pipe aligned with the strobe level stage
    prl_sync_pipe #(.W(AD_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_pipe (
        .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s)
    );

    assign unused_ad_bit = ad_s[0];

    prl_array_stub #(.ADDR_W(ADDR_W), .DATA_W(AD_W)) u_array (
        .addr(word_addr),
        .data(rom_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;

        if (hi_lvl || lo_lvl || st_q.armed) begin
            st_d.mode = PRL_ADDR_IN;
        end

        if (hi_fall) begin
            st_d.hi    = ad_s[HI_BITS-1:0];
            st_d.armed = 1'b1;
            st_d.mode  = PRL_ADDR_IN;
        end

        if (lo_fall) begin
            if (st_q.armed) begin
                st_d.lo    = ad_s[LO_MSB:LO_LSB];
                st_d.cnt   = ad_s[CNT_MSB:CNT_LSB];
                st_d.armed = 1'b0;
                st_d.mode  = PRL_ACTIVE;
            end else begin
                st_d.err   = 1'b1;
                st_d.mode  = PRL_STANDBY;
            end
        end else if (rd_fall && (st_q.mode == PRL_ACTIVE)) begin
            st_d.dout = rom_word;
            st_d.cnt  = st_q.cnt + CNT_BITS'(1);
        end

        st_d.oe = (st_d.mode == PRL_ACTIVE) && !rd_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= PRL_STANDBY;
            st_q.hi    <= '0;
            st_q.lo    <= '0;
            st_q.cnt   <= '0;
            st_q.armed <= 1'b0;
            st_q.err   <= 1'b0;
            st_q.oe    <= 1'b0;
            st_q.dout  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_addr = {st_q.hi, st_q.lo, st_q.cnt};
    assign mode      = st_q.mode;
    assign seq_err   = st_q.err;
    assign ad_oe     = st_q.oe;
    assign ad_out    = st_q.oe ? st_q.dout : '0;

endmodule

// File: rtl/prl_front_chk.sv
module prl_front_chk #(
    parameter int AD_W     = 16,
    parameter int CNT_BITS = 8,
    parameter int ADDR_W   = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AD_W-1:0]   ad_out,
    input logic              ad_oe,
    input logic [ADDR_W-1:0] word_addr,
    input logic [1:0]        mode,
    input logic              seq_err
);

    // R7
    oe_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (mode == 2'd2));

    // R7
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |-> (ad_out == '0));

    // R9
    err_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $stable(word_addr));

    // R9
    err_to_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (mode == 2'd0));

    // R9
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !seq_err);

    // R5
    page_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2) && ($past(mode) == 2'd2)) |-> $stable(word_addr[ADDR_W-1:CNT_BITS]));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2) && ($past(mode) == 2'd2) && !$stable(word_addr[CNT_BITS-1:0]))
        |-> (word_addr[CNT_BITS-1:0] == $past(word_addr[CNT_BITS-1:0]) + CNT_BITS'(1)));

    // R1
    legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

endmodule

bind prl_front prl_front_chk #(
    .AD_W    (AD_W),
    .CNT_BITS(CNT_BITS),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .word_addr(word_addr),
    .mode     (mode),
    .seq_err  (seq_err)
);

// File: tb/sim_prl_front.sv
module sim_prl_front;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale_hi = 1'b0;
    logic        ale_lo = 1'b0;
    logic        rd_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [21:0] word_addr;
    logic [1:0]  mode;
    logic        seq_err;

    prl_front u0 (
        .clk(clk), .rst_n(rst_n), .ale_hi(ale_hi), .ale_lo(ale_lo), .rd_n(rd_n),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .word_addr(word_addr),
        .mode(mode), .seq_err(seq_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int err_seen = 0;
    int err_exp  = 0;
    bit done = 1'b0;
    bit oe_prev = 1'b0;
    logic [15:0] exp_q[$];

    logic [6:0] m_hi = '0;
    logic [6:0] m_lo = '0;
    logic [7:0] m_cnt = '0;
    bit         m_armed = 1'b0;
    logic [1:0] m_mode = 2'd0;

    function automatic logic [21:0] m_addr();
        return {m_hi, m_lo, m_cnt};
    endfunction

    function automatic logic [15:0] exp_data(logic [21:0] a);
        return a[15:0] ^ {a[21:16], 10'b0};
    endfunction

    task automatic chk(bit ok, string tag, int unsigned act, int unsigned exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_state(string tag);
        chk(word_addr == m_addr(), {tag, " word_addr"}, word_addr, m_addr());
        chk(mode == m_mode, {tag, " mode"}, mode, m_mode);
    endtask

    task automatic load_hi(logic [15:0] v);
        ad_in  = v;
        ale_hi = 1'b1;
        wait_cyc(4);
        chk(mode == 2'd1, "R10 mode while ale_hi high", mode, 1);
        ale_hi = 1'b0;
        wait_cyc(5);
        m_hi    = v[6:0];
        m_armed = 1'b1;
        m_mode  = 2'd1;
    endtask

    task automatic load_lo(logic [15:0] v);
        ad_in  = v;
        ale_lo = 1'b1;
        wait_cyc(4);
        chk(mode == 2'd1, "R10 mode while ale_lo high", mode, 1);
        ale_lo = 1'b0;
        wait_cyc(5);
        if (m_armed) begin
            m_lo    = v[15:9];
            m_cnt   = v[8:1];
            m_armed = 1'b0;
            m_mode  = 2'd2;
        end else begin
            m_mode = 2'd0;
            err_exp++;
        end
    endtask

    // driver: pushes the expected read word, then strobes
    task automatic rd_pulse();
        rd_n = 1'b0;
        if (m_mode == 2'd2) begin
            exp_q.push_back(exp_data(m_addr()));
            m_cnt = m_cnt + 8'd1;
        end
        wait_cyc(4);
        chk(ad_oe == (m_mode == 2'd2), "R7 oe during read", ad_oe, (m_mode == 2'd2));
        rd_n = 1'b1;
        wait_cyc(5);
        chk(ad_oe == 1'b0, "R7 oe after read", ad_oe, 0);
    endtask

    // monitor: pops expected words when the bus turns on
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ad_oe && !oe_prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected bus drive", ad_out, 0);
                end else begin
                    automatic logic [15:0] e = exp_q.pop_front();
                    chk(ad_out == e, "R8 read data", ad_out, e);
                end
            end
            if (!ad_oe && ad_out != 16'h0) begin
                n_fail++;
                $display("FAIL R7 bus not quiet actual=0x%0h expected=0x0", ad_out);
            end
            if (seq_err) err_seen++;
        end
        oe_prev = ad_oe;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        chk(mode == 2'd0, "R1 mode", mode, 0);
        chk(word_addr == 22'h0, "R1 word_addr", word_addr, 0);
        chk(ad_oe == 1'b0, "R1 ad_oe", ad_oe, 0);
        chk(ad_out == 16'h0, "R1 ad_out", ad_out, 0);
        chk(seq_err == 1'b0, "R1 seq_err", seq_err, 0);

        // R9 low half straight after reset
        load_lo(16'h1234);
        chk_state("R9 after early low half");
        chk(err_seen == err_exp, "R9 error pulses", err_seen, err_exp);

        // R2 high half with unused bits set
        load_hi(16'hFF85);
        chk_state("R2 high half");

        // R3 low half with bit 0 set
        load_lo(16'h7A21);
        chk_state("R3 low half");
        chk(word_addr == 22'h02BD10, "R3 absolute address", word_addr, 22'h02BD10);

        // R4 sequential reads
        for (int i = 0; i < 3; i++) begin
            rd_pulse();
            chk_state("R4 step");
        end

        // R9 repeated low half with no new high half
        load_lo(16'h0101);
        chk_state("R9 after repeated low half");
        chk(err_seen == err_exp, "R9 error pulses", err_seen, err_exp);

        // R6 read strobe in standby
        rd_pulse();
        chk_state("R6 standby read");

        // R6 read strobe in address-input mode
        load_hi(16'h0012);
        rd_pulse();
        chk_state("R6 address-input read");

        // R5 wrap from near page end
        load_lo(16'h03FD);
        chk_state("R3 second load");
        for (int i = 0; i < 3; i++) begin
            rd_pulse();
            chk_state("R5 wrap");
        end
        chk(word_addr[7:0] == 8'h01, "R5 counter after wrap", word_addr[7:0], 1);
        chk(word_addr[21:8] == {7'h12, 7'h01}, "R5 page kept", word_addr[21:8], {7'h12, 7'h01});

        // R5 seed at last word of the last page
        load_hi(16'hAB7F);
        load_lo(16'hFFFF);
        chk_state("R3 top page load");
        rd_pulse();
        chk(word_addr == 22'h3FFF00, "R5 top page wrap", word_addr, 22'h3FFF00);

        wait_cyc(3);
        chk(exp_q.size() == 0, "R8 all reads seen", exp_q.size(), 0);
        chk(err_seen == err_exp, "R9 total error pulses", err_seen, err_exp);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule